// File: doc/BRIEF.md
# Serial Register Access Port

This block is the serial slave front end of a small register file. A host sends one 16-bit word per chip-select window, MSB first. The word's top bits name a register group, a read-only flag and a readback selector, and the lower twelve bits carry data. At the same time the block shifts back a 16-bit response word. The register file supplies that word through a readback mux that the block steers.

The serial inputs are synchronised into the system clock domain, and the block counts serial clock rising edges while chip-select is low. When chip-select rises, the access is judged. With exactly sixteen clocks, the readback selection is updated and, unless the read-only flag is set, a one-cycle write strobe carries group and data to the register file. With any other count, nothing is committed and a one-cycle count-failure pulse is raised. The block also keeps the system configuration group locally. Reserved fields are kept at zero, and a reset-length bit is forced high by reset and by entry into a restart or fail-safe mode.

Top module: `serial_cfg_port`

## Requirements
- R1: An access is accepted only when exactly 16 serial clock rising edges occur while csN is low. With any other count (0, 15, 17, 20, ...) there is no write strobe and no change to rbSel or sysCfg.
- R2: Each access whose count is not 16 produces exactly one cntFail pulse, one system clock cycle wide, after csN rises. Accepted accesses produce none.
- R3: Frame bits 15:14 are the group (01 interrupt, 10 system configuration, 11 physical layer). An accepted write presents them on wrGroup. Group 00 never produces a write strobe.
- R4: When frame bit 12 (read-only) is 1, an accepted access produces no write strobe and leaves sysCfg unchanged.
- R5: An accepted access with bit 12 = 0 and a non-zero group produces exactly one wrStb pulse, with wrData equal to frame bits 11:0.
- R6: rbSel = {bits 15:14, bit 13} of the most recent accepted access, where bit 13 = 1 selects the general-purpose register and 0 the group's own feedback register. It is 000 after reset.
- R7: The response on miso is MSB first. It is the value of rbData captured when csN falls. Each bit is valid before the serial clock rising edge that samples it, and miso advances on serial clock falling edges.
- R8: An accepted write to group 10 loads sysCfg with wrData, with reserved bits 11, 10, 9 and 5 forced to 0. The other bits are: bit 8 reset length, bits 7:6 supply control, bit 4 current monitor, bit 3 wake enable, bit 2 wake sampling, bit 1 inhibit enable, bit 0 inhibit level.
- R9: After reset, sysCfg = 0x100 (only the reset-length bit set), rbSel = 000, and wrStb and cntFail are low.
- R10: A failSafeEntry pulse sets sysCfg bit 8 on the next clock and leaves the other bits unchanged.
- R11: Accepted writes to groups 01 and 11 do not change sysCfg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host, idle low |
| csN | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial response data |
| rbData | input | 16 | Readback word from the register file, chosen by rbSel |
| rbSel | output | 3 | Readback mux select {group, general-purpose select} |
| wrStb | output | 1 | One-cycle write strobe |
| wrGroup | output | 2 | Group of the write |
| wrData | output | 12 | Data of the write |
| cntFail | output | 1 | One-cycle clock-count failure pulse |
| failSafeEntry | input | 1 | Restart or fail-safe mode entry; sets the reset-length bit |
| sysCfg | output | 12 | System configuration register contents |

## Verification
Some properties are checked on every cycle: the bit counter stays within its saturation bound, the failure pulse and the write strobe are single cycles and never coincide with a commit, and a write strobe never names group 00. They also check that rbSel holds between accepted accesses and that a fail-safe entry always leaves the reset-length bit set. The following can only be shown by the bench's frames: the correctness of the captured data, the MSB-first response word, the rejection of short, long and empty frames, and the masking of reserved configuration bits. The bench mixes directed corner frames with seeded random words and clock counts.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  typedef struct packed {
    logic loadTx;
    logic shiftTx;
    logic shiftRx;
    logic commitRd;
    logic commitWr;
  } frameStb_t;
endpackage

// File: rtl/sfr_ctrl.sv
module sfr_ctrl
  import sfr_pkg::*;
#(
  parameter int FRAME_BITS  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclk,
  input  logic      csN,
  input  logic      mosi,
  input  logic      hdrWrite,
  output frameStb_t stb,
  output logic      mosiBit,
  output logic      cntFail
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_BITS + 1);

  logic [SYNC_STAGES-1:0] sclkPipe, csPipe, mosiPipe;
  logic sclkPrev, csPrev;
  logic [CNT_W-1:0] bitCnt;

  // synchroniser chains, one per serial input
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            sclkPipe[0] <= 1'b0;
            csPipe[0]   <= 1'b1;
            mosiPipe[0] <= 1'b0;
          end else begin
            sclkPipe[0] <= sclk;
            csPipe[0]   <= csN;
            mosiPipe[0] <= mosi;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            sclkPipe[s] <= 1'b0;
            csPipe[s]   <= 1'b1;
            mosiPipe[s] <= 1'b0;
          end else begin
            sclkPipe[s] <= sclkPipe[s-1];
            csPipe[s]   <= csPipe[s-1];
            mosiPipe[s] <= mosiPipe[s-1];
          end
        end
      end
    end
  endgenerate

  logic sclkS, csS;
  assign sclkS   = sclkPipe[SYNC_STAGES-1];
  assign csS     = csPipe[SYNC_STAGES-1];
  assign mosiBit = mosiPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      csPrev   <= 1'b1;
    end else begin
      sclkPrev <= sclkS;
      csPrev   <= csS;
    end
  end

  logic csFall, csRise, sclkRise, sclkFall, countOk;
  assign csFall   = csPrev & ~csS;
  assign csRise   = ~csPrev & csS;
  assign sclkRise = ~sclkPrev & sclkS & ~csS;
  assign sclkFall = sclkPrev & ~sclkS & ~csS;
  assign countOk  = (bitCnt == CNT_FULL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (csFall) begin
      bitCnt <= '0;
    end else if (sclkRise && bitCnt != CNT_MAX) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    stb.loadTx   = csFall;
    stb.shiftTx  = sclkFall;
    stb.shiftRx  = sclkRise;
    stb.commitRd = csRise & countOk;
    stb.commitWr = csRise & countOk & hdrWrite;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cntFail <= 1'b0;
    else       cntFail <= csRise & ~countOk;
  end

  // R1: counter saturates one past a full frame
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_MAX);
  // R2: failure pulse lasts one cycle
  p_fail_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    cntFail |=> !cntFail);
  // R1: a rejected frame never also commits
  p_fail_no_commit_r1: assert property (@(posedge clk) disable iff (!rstN)
    cntFail |-> !$past(stb.commitRd));
endmodule

// File: rtl/sfr_dp.sv
module sfr_dp
  import sfr_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int DATA_W     = FRAME_BITS - 4,
  parameter logic [DATA_W-1:0] RSVD_MASK = 12'hE20,
  parameter int RLC_BIT    = 8,
  parameter logic [1:0] SYS_GROUP = 2'b10
) (
  input  logic              clk,
  input  logic              rstN,
  input  frameStb_t         stb,
  input  logic              mosiBit,
  input  logic [FRAME_BITS-1:0] rbData,
  input  logic              failSafeEntry,
  output logic              hdrWrite,
  output logic              miso,
  output logic [2:0]        rbSel,
  output logic              wrStb,
  output logic [1:0]        wrGroup,
  output logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] sysCfg
);
  localparam int GRP_HI = FRAME_BITS - 1;
  localparam int GRP_LO = FRAME_BITS - 2;
  localparam int SEL_B  = FRAME_BITS - 3;
  localparam int RO_B   = FRAME_BITS - 4;
  localparam logic [DATA_W-1:0] CFG_RESET = DATA_W'(1) << RLC_BIT;

  logic [FRAME_BITS-1:0] rxWord, txWord;
  logic [1:0] rxGroup;

  assign rxGroup  = rxWord[GRP_HI:GRP_LO];
  assign hdrWrite = ~rxWord[RO_B] & (rxGroup != 2'b00);
  assign miso     = txWord[FRAME_BITS-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rxWord <= '0;
    else if (stb.shiftRx) rxWord <= {rxWord[FRAME_BITS-2:0], mosiBit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            txWord <= '0;
    else if (stb.loadTx)  txWord <= rbData;
    else if (stb.shiftTx) txWord <= {txWord[FRAME_BITS-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rbSel <= 3'b000;
    else if (stb.commitRd) rbSel <= {rxGroup, rxWord[SEL_B]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrStb   <= 1'b0;
      wrGroup <= 2'b00;
      wrData  <= '0;
    end else begin
      wrStb <= stb.commitWr;
      if (stb.commitWr) begin
        wrGroup <= rxGroup;
        wrData  <= rxWord[DATA_W-1:0];
      end
    end
  end

  logic [DATA_W-1:0] cfgNext;
  always_comb begin
    cfgNext = sysCfg;
    if (stb.commitWr && rxGroup == SYS_GROUP)
      cfgNext = rxWord[DATA_W-1:0] & ~RSVD_MASK;
    if (failSafeEntry)
      cfgNext[RLC_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sysCfg <= CFG_RESET;
    else       sysCfg <= cfgNext;
  end

  // R6: readback select changes only on accepted frames
  p_rbsel_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !stb.commitRd |=> $stable(rbSel));
  // R3: group 00 never produces a write
  p_wr_group_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrStb |-> wrGroup != 2'b00);
  // R5: every strobe follows a commit decision of the control
  p_wr_from_commit_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrStb |-> $past(stb.commitWr));
  // R5: strobe is a single cycle
  p_wr_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrStb |=> !wrStb);
  // R10: fail-safe entry leaves reset-length bit set
  p_failsafe_rlc_r10: assert property (@(posedge clk) disable iff (!rstN)
    failSafeEntry |=> sysCfg[RLC_BIT]);
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port #(
  parameter int FRAME_BITS  = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = FRAME_BITS - 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclk,
  input  logic                  csN,
  input  logic                  mosi,
  output logic                  miso,
  input  logic [FRAME_BITS-1:0] rbData,
  output logic [2:0]            rbSel,
  output logic                  wrStb,
  output logic [1:0]            wrGroup,
  output logic [DATA_W-1:0]     wrData,
  output logic                  cntFail,
  input  logic                  failSafeEntry,
  output logic [DATA_W-1:0]     sysCfg
);
  sfr_pkg::frameStb_t stb;
  logic mosiBit, hdrWrite;

  sfr_ctrl #(.FRAME_BITS(FRAME_BITS), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi),
    .hdrWrite(hdrWrite), .stb(stb), .mosiBit(mosiBit), .cntFail(cntFail)
  );

  sfr_dp #(.FRAME_BITS(FRAME_BITS), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .mosiBit(mosiBit), .rbData(rbData),
    .failSafeEntry(failSafeEntry), .hdrWrite(hdrWrite), .miso(miso),
    .rbSel(rbSel), .wrStb(wrStb), .wrGroup(wrGroup), .wrData(wrData),
    .sysCfg(sysCfg)
  );
endmodule

// File: tb/tb_serial_cfg_port.sv
module tb_serial_cfg_port;
  logic clk = 1'b0, rstN = 1'b0, sclk = 1'b0, csN = 1'b1, mosi = 1'b0;
  logic failSafeEntry = 1'b0;
  logic miso, wrStb, cntFail;
  logic [15:0] rbData;
  logic [2:0] rbSel;
  logic [1:0] wrGroup;
  logic [11:0] wrData, sysCfg;

  int checks = 0, failures = 0;
  int wrCount = 0, failCount = 0;
  logic [1:0] lastGroup = 2'b00;
  logic [11:0] lastData = '0;
  logic [2:0] expSel = 3'b000;
  logic [11:0] expSys = 12'h100;

  always #10 clk = ~clk;

  function automatic logic [15:0] rbFn(logic [2:0] s);
    return 16'hA50F ^ {s, 5'b00000, s, 2'b00, s};
  endfunction

  assign rbData = rbFn(rbSel);

  serial_cfg_port dut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi), .miso(miso),
    .rbData(rbData), .rbSel(rbSel), .wrStb(wrStb), .wrGroup(wrGroup),
    .wrData(wrData), .cntFail(cntFail), .failSafeEntry(failSafeEntry),
    .sysCfg(sysCfg)
  );

  always @(negedge clk) begin
    if (wrStb) begin
      wrCount++;
      lastGroup = wrGroup;
      lastData  = wrData;
    end
    if (cntFail) failCount++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runFrame(input logic [15:0] word, input int nClk);
    logic [15:0] got;
    logic [15:0] expResp;
    int wr0, fl0;
    logic expWr;
    got = '0;
    expResp = rbFn(expSel);
    wr0 = wrCount;
    fl0 = failCount;
    @(negedge clk) csN = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nClk; i++) begin
      mosi = (i < 16) ? word[15-i] : 1'($urandom % 2);
      repeat (6) @(negedge clk);
      if (i < 16) got[15-i] = miso;
      sclk = 1'b1;
      repeat (6) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (6) @(negedge clk);
    csN = 1'b1;
    repeat (12) @(negedge clk);
    if (nClk >= 16) chk("R7 response word", 32'(got), 32'(expResp));
    if (nClk == 16) begin
      expWr = !word[12] && word[15:14] != 2'b00;
      chk("R2 no fail pulse on good frame", 32'(failCount - fl0), 0);
      chk("R3/R4/R5 write strobe count", 32'(wrCount - wr0), expWr ? 1 : 0);
      if (expWr) begin
        chk("R3 write group", 32'(lastGroup), 32'(word[15:14]));
        chk("R5 write data", 32'(lastData), 32'(word[11:0]));
        if (word[15:14] == 2'b10) expSys = word[11:0] & ~12'hE20;
      end
      expSel = {word[15:14], word[13]};
    end else begin
      chk("R2 one fail pulse", 32'(failCount - fl0), 1);
      chk("R1 no write on bad count", 32'(wrCount - wr0), 0);
    end
    chk("R6 readback select", 32'(rbSel), 32'(expSel));
    chk("R8/R11 sysCfg", 32'(sysCfg), 32'(expSys));
  endtask

  task automatic pulseFs();
    @(negedge clk) failSafeEntry = 1'b1;
    @(negedge clk) failSafeEntry = 1'b0;
    expSys[8] = 1'b1;
    chk("R10 fail-safe sets reset length", 32'(sysCfg), 32'(expSys));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seedDummy;
    int nClk;
    int r;
    seedDummy = $urandom(32'h5EED);
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 sysCfg reset", 32'(sysCfg), 32'h100);
    chk("R9 rbSel reset", 32'(rbSel), 0);
    chk("R9 strobes idle", 32'({wrStb, cntFail}), 0);

    runFrame(16'h8FFF, 16);          // R8: reserved bits forced 0 -> 0x1DF
    chk("R8 masked value", 32'(sysCfg), 32'h1DF);
    runFrame(16'h8000, 16);          // clear all incl. reset length
    pulseFs();                        // R10
    runFrame(16'h4ABC, 16);          // R11 group 01 write
    runFrame(16'hCFFF, 16);          // R11 group 11 write
    runFrame(16'h9555, 16);          // R4 read-only to group 10
    runFrame(16'h2123, 16);          // R3 group 00, no write
    runFrame(16'h8055, 15);          // R1 short
    runFrame(16'h8055, 17);          // R1 long
    runFrame(16'h8055, 0);           // R1 empty
    runFrame(16'hA0C3, 16);          // R6 general-purpose select
    runFrame(16'h3000, 16);          // R7 response from previous select

    for (int k = 0; k < 120; k++) begin
      r = int'($urandom % 8);
      if (r < 5)       nClk = 16;
      else if (r == 5) nClk = 15;
      else if (r == 6) nClk = 17;
      else             nClk = ($urandom % 2) ? 0 : 20;
      runFrame(16'($urandom), nClk);
      if ($urandom % 10 == 0) pulseFs();
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule